// File: doc/BRIEF.md
# Writeback Slot Allocator

This block sits between the execution units of an out-of-order core and the commit stage. Every cycle up to `NCMP` finished instructions arrive, each with a tag, a latency, three status flags (done, fault, killed) and up to `NDEST` destination registers. The block keeps a circular buffer of `DEPTH` rows. Each row stands for one future cycle and has `WB_W` slots. An arriving instruction goes into the row its latency names, in the first free slot. If that row is full, it goes into the next row, and so on.

Each clock the row for the current cycle is shown on the commit port, one output lane per slot, and is then emptied. For each shown slot whose instruction finished cleanly, the block raises the scoreboard ready bit of every destination register the instruction names. When no row within reach has room, a finishing instruction is refused and its stall line goes high. The source has to hold that instruction and offer it again later.

Top module: `wb_slot_alloc`

## Requirements
- R1: After reset, no commit lane is valid, no scoreboard bit is raised and no stall line is high.
- R2: An instruction offered in cycle k with a latency field of L (1 to DEPTH-1) is shown on the commit port in cycle k+L.
- R3: Within a row, instructions take slots from slot 0 upward. Instructions from earlier cycles come first, and within one cycle lane 0 comes before lane 1 and lane 2. The commit valid bits are always a contiguous run starting at slot 0.
- R4: When the target row already holds WB_W instructions, the instruction goes to the first free slot of the next row that has room. It is then shown one cycle later per row skipped.
- R5: When every row from the target up to DEPTH-1 rows ahead is full, the lane's stall output is high in that same cycle. The instruction is not stored and never appears on the commit port.
- R6: A row is emptied in the cycle it is shown. Slots are reused after the buffer wraps, and nothing is shown twice.
- R7: For each valid commit slot whose instruction has done=1, fault=0 and killed=0, `sb_set` raises the bit of every destination whose valid flag is 1, in the same cycle as the commit output. A destination whose valid flag is 0 raises nothing.
- R8: An instruction that is killed, faulted or not done is still shown as valid on the commit port. Its `cmt_ok` bit is 0 and it raises no scoreboard bit.
- R9: Storing new instructions in a cycle does not disturb the row being shown and emptied in that cycle.
- R10: A latency field of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fin_vld | input | NCMP | Per lane: a finished instruction is offered |
| fin_tag | input | NCMP*TAG_W | Per lane instruction tag |
| fin_lat | input | NCMP*log2(DEPTH) | Per lane cycles until writeback (0 means 1) |
| fin_done | input | NCMP | Instruction executed |
| fin_fault | input | NCMP | Instruction raised a fault |
| fin_killed | input | NCMP | Instruction was squashed |
| fin_dvld | input | NCMP*NDEST | Per destination valid flag |
| fin_dreg | input | NCMP*NDEST*log2(NREGS) | Per destination register number |
| fin_stall | output | NCMP | Lane refused: no free slot within reach |
| cmt_vld | output | WB_W | Commit slot valid |
| cmt_tag | output | WB_W*TAG_W | Commit slot tag |
| cmt_ok | output | WB_W | Commit slot finished cleanly |
| sb_set | output | NREGS | Scoreboard ready bits raised this cycle |

## Verification
Storing new instructions and showing the head row fall in the same cycle. A stream of latency-1 instructions is sent every cycle for more than DEPTH cycles, so the buffer wraps. This means the row being written is always the one directly behind the row being emptied. Each cycle the commit lanes must show exactly the pair of tags offered one cycle before, with no leftover and no repeat. Spills are also timed so that the spill target is written while an earlier row drains, and the spilled instruction must show up exactly one cycle after its neighbours.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    typedef struct packed {
        logic done;
        logic fault;
        logic killed;
    } wbs_flags_t;

    // Clean completion: may release its destination registers
    function automatic logic wbs_ready(wbs_flags_t f);
        return f.done & ~f.fault & ~f.killed;
    endfunction

endpackage

// File: rtl/wbs_row_pick.sv
module wbs_row_pick #(
    parameter int DEPTH  = 4,
    parameter int WB_W   = 2,
    parameter int ROW_W  = 2,
    parameter int CNT_W  = 2,
    parameter int SLOT_W = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req,
    input  logic [ROW_W-1:0]                 hd,
    input  logic [ROW_W-1:0]                 lat,
    input  logic [DEPTH-1:0][CNT_W-1:0]      cnt_in,
    output logic                             found,
    output logic [ROW_W-1:0]                 row,
    output logic [SLOT_W-1:0]                slot,
    output logic [DEPTH-1:0][CNT_W-1:0]      cnt_out
);
    localparam logic [ROW_W-1:0] ONE_ROW = ROW_W'(1);
    localparam logic [ROW_W-1:0] LAST    = ROW_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(WB_W);

    logic [ROW_W-1:0] eff;
    logic [ROW_W-1:0] r;

    // Scan rows ahead of the head, starting at the latency offset
    always_comb begin
        eff     = (lat == '0) ? ONE_ROW : lat;
        found   = 1'b0;
        row     = hd;
        slot    = '0;
        r       = hd;
        cnt_out = cnt_in;
        for (int off = 1; off < DEPTH; off++) begin
            r = hd + ROW_W'(off);
            if (!found && (ROW_W'(off) >= eff) && (cnt_in[r] < FULL)) begin
                found = 1'b1;
                row   = r;
                slot  = cnt_in[r][SLOT_W-1:0];
            end
        end
        if (req && found) begin
            cnt_out[row] = cnt_in[row] + CNT_W'(1);
        end
    end

    // R5
    stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !found) |-> (cnt_in[hd + LAST] == FULL));

endmodule

// File: rtl/wbs_sb_decode.sv
module wbs_sb_decode #(
    parameter int WB_W  = 2,
    parameter int NDEST = 2,
    parameter int REG_W = 5,
    parameter int NREGS = 32
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [WB_W-1:0]                         ok,
    input  logic [WB_W-1:0][NDEST-1:0]              dvld,
    input  logic [WB_W-1:0][NDEST-1:0][REG_W-1:0]   dreg,
    output logic [NREGS-1:0]                        sb_set
);
    always_comb begin
        sb_set = '0;
        for (int s = 0; s < WB_W; s++) begin
            for (int d = 0; d < NDEST; d++) begin
                if (ok[s] && dvld[s][d]) begin
                    sb_set[dreg[s][d]] = 1'b1;
                end
            end
        end
    end

    // R7
    sb_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_set != '0) |-> (ok != '0));

endmodule

// File: rtl/wb_slot_alloc.sv
module wb_slot_alloc
    import wbs_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WB_W  = 2,
    parameter int NCMP  = 3,
    parameter int NDEST = 2,
    parameter int TAG_W = 6,
    parameter int NREGS = 32
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [NCMP-1:0]                               fin_vld,
    input  logic [NCMP-1:0][TAG_W-1:0]                    fin_tag,
    input  logic [NCMP-1:0][$clog2(DEPTH)-1:0]            fin_lat,
    input  logic [NCMP-1:0]                               fin_done,
    input  logic [NCMP-1:0]                               fin_fault,
    input  logic [NCMP-1:0]                               fin_killed,
    input  logic [NCMP-1:0][NDEST-1:0]                    fin_dvld,
    input  logic [NCMP-1:0][NDEST-1:0][$clog2(NREGS)-1:0] fin_dreg,
    output logic [NCMP-1:0]                               fin_stall,
    output logic [WB_W-1:0]                               cmt_vld,
    output logic [WB_W-1:0][TAG_W-1:0]                    cmt_tag,
    output logic [WB_W-1:0]                               cmt_ok,
    output logic [NREGS-1:0]                              sb_set
);
    localparam int ROW_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(WB_W + 1);
    localparam int SLOT_W = (WB_W > 1) ? $clog2(WB_W) : 1;
    localparam int REG_W  = $clog2(NREGS);

    typedef struct packed {
        logic [TAG_W-1:0]                  tag;
        wbs_flags_t                        flg;
        logic [NDEST-1:0]                  dvld;
        logic [NDEST-1:0][REG_W-1:0]       dreg;
    } ent_t;

    typedef struct packed {
        logic [ROW_W-1:0]                  hd;
        logic [DEPTH-1:0][CNT_W-1:0]       cnt;
        ent_t [DEPTH-1:0][WB_W-1:0]        ent;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0][CNT_W-1:0] cnt_ch [NCMP+1];
    logic [NCMP-1:0]             hit;
    logic [ROW_W-1:0]            prow  [NCMP];
    logic [SLOT_W-1:0]           pslot [NCMP];
    ent_t                        fin_ent [NCMP];

    assign cnt_ch[0] = st_q.cnt;

    // One picker per lane; each sees the counts left by the lanes before it
    for (genvar l = 0; l < NCMP; l++) begin : g_lane
        assign fin_ent[l].tag  = fin_tag[l];
        assign fin_ent[l].flg  = '{done: fin_done[l], fault: fin_fault[l], killed: fin_killed[l]};
        assign fin_ent[l].dvld = fin_dvld[l];
        assign fin_ent[l].dreg = fin_dreg[l];

        wbs_row_pick #(
            .DEPTH (DEPTH),
            .WB_W  (WB_W),
            .ROW_W (ROW_W),
            .CNT_W (CNT_W),
            .SLOT_W(SLOT_W)
        ) u_pick (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (fin_vld[l]),
            .hd     (st_q.hd),
            .lat    (fin_lat[l]),
            .cnt_in (cnt_ch[l]),
            .found  (hit[l]),
            .row    (prow[l]),
            .slot   (pslot[l]),
            .cnt_out(cnt_ch[l+1])
        );

        assign fin_stall[l] = fin_vld[l] & ~hit[l];
    end

    // Next state: drain and clear head row, store accepted lanes
    always_comb begin
        st_d                = st_q;
        st_d.hd             = st_q.hd + ROW_W'(1);
        st_d.cnt            = cnt_ch[NCMP];
        st_d.cnt[st_q.hd]   = '0;
        st_d.ent[st_q.hd]   = '0;
        for (int l = 0; l < NCMP; l++) begin
            if (fin_vld[l] && hit[l]) begin
                st_d.ent[prow[l]][pslot[l]] = fin_ent[l];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Head row read-out
    ent_t [WB_W-1:0]                        hrow;
    logic [WB_W-1:0][NDEST-1:0]             h_dvld;
    logic [WB_W-1:0][NDEST-1:0][REG_W-1:0]  h_dreg;

    assign hrow = st_q.ent[st_q.hd];

    always_comb begin
        for (int s = 0; s < WB_W; s++) begin
            cmt_vld[s] = CNT_W'(s) < st_q.cnt[st_q.hd];
            cmt_tag[s] = hrow[s].tag;
            cmt_ok[s]  = cmt_vld[s] & wbs_ready(hrow[s].flg);
            h_dvld[s]  = hrow[s].dvld;
            h_dreg[s]  = hrow[s].dreg;
        end
    end

    wbs_sb_decode #(
        .WB_W (WB_W),
        .NDEST(NDEST),
        .REG_W(REG_W),
        .NREGS(NREGS)
    ) u_sb (
        .clk   (clk),
        .rst_n (rst_n),
        .ok    (cmt_ok),
        .dvld  (h_dvld),
        .dreg  (h_dreg),
        .sb_set(sb_set)
    );

    // R6
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.hd == $past(st_q.hd) + ROW_W'(1)));

    // R6
    drained_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.cnt[$past(st_q.hd)] == '0));

    // R2
    lane0_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_vld[0] && hit[0]) |=> (st_q.cnt[$past(prow[0])] != $past(st_q.cnt[prow[0]])));

    // R3
    cmt_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmt_vld[0] |-> (cmt_vld == '0));

    // R9
    row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt[st_q.hd] <= CNT_W'(WB_W));

endmodule

// File: tb/test_wb_slot_alloc.sv
`timescale 1ns/1ps
module test_wb_slot_alloc;
    localparam int DEPTH = 4;
    localparam int WB_W  = 2;
    localparam int NCMP  = 3;
    localparam int NDEST = 2;
    localparam int TAG_W = 6;
    localparam int NREGS = 32;
    localparam int ROW_W = 2;
    localparam int REG_W = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic [NCMP-1:0]                         fin_vld;
    logic [NCMP-1:0][TAG_W-1:0]              fin_tag;
    logic [NCMP-1:0][ROW_W-1:0]              fin_lat;
    logic [NCMP-1:0]                         fin_done;
    logic [NCMP-1:0]                         fin_fault;
    logic [NCMP-1:0]                         fin_killed;
    logic [NCMP-1:0][NDEST-1:0]              fin_dvld;
    logic [NCMP-1:0][NDEST-1:0][REG_W-1:0]   fin_dreg;
    logic [NCMP-1:0]                         fin_stall;
    logic [WB_W-1:0]                         cmt_vld;
    logic [WB_W-1:0][TAG_W-1:0]              cmt_tag;
    logic [WB_W-1:0]                         cmt_ok;
    logic [NREGS-1:0]                        sb_set;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    wb_slot_alloc #(
        .DEPTH(DEPTH), .WB_W(WB_W), .NCMP(NCMP),
        .NDEST(NDEST), .TAG_W(TAG_W), .NREGS(NREGS)
    ) i_wb_slot_alloc (
        .clk(clk), .rst_n(rst_n),
        .fin_vld(fin_vld), .fin_tag(fin_tag), .fin_lat(fin_lat),
        .fin_done(fin_done), .fin_fault(fin_fault), .fin_killed(fin_killed),
        .fin_dvld(fin_dvld), .fin_dreg(fin_dreg), .fin_stall(fin_stall),
        .cmt_vld(cmt_vld), .cmt_tag(cmt_tag), .cmt_ok(cmt_ok), .sb_set(sb_set)
    );

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic clear_lanes();
        fin_vld = '0; fin_tag = '0; fin_lat = '0;
        fin_done = '0; fin_fault = '0; fin_killed = '0;
        fin_dvld = '0; fin_dreg = '0;
    endtask

    task automatic set_lane(input int l, input int tag, input int lat, input bit dn,
                            input bit flt, input bit kil, input logic [1:0] dv,
                            input int r0, input int r1);
        fin_vld[l]    = 1'b1;
        fin_tag[l]    = TAG_W'(tag);
        fin_lat[l]    = ROW_W'(lat);
        fin_done[l]   = dn;
        fin_fault[l]  = flt;
        fin_killed[l] = kil;
        fin_dvld[l]   = dv;
        fin_dreg[l][0] = REG_W'(r0);
        fin_dreg[l][1] = REG_W'(r1);
    endtask

    // Edge, then sample 1 ns later
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        check("R1 cmt_vld", 64'(cmt_vld), 64'h0);
        check("R1 sb_set", 64'(sb_set), 64'h0);
        check("R1 fin_stall", 64'(fin_stall), 64'h0);
    endtask

    task automatic t_latency();
        set_lane(0, 5, 3, 1, 0, 0, 2'b11, 3, 7);
        #1 check("R2 no stall", 64'(fin_stall), 64'h0);
        tick(); clear_lanes(); #0.1;
        check("R2 early k+1", 64'(cmt_vld), 64'h0);
        tick();
        check("R2 early k+2", 64'(cmt_vld), 64'h0);
        tick();
        check("R2 valid k+3", 64'(cmt_vld), 64'h1);
        check("R2 tag", 64'(cmt_tag[0]), 64'd5);
        check("R7 sb bits", 64'(sb_set), 64'h88);
        tick();
        check("R6 not repeated", 64'(cmt_vld), 64'h0);
    endtask

    task automatic t_spill();
        set_lane(0, 10, 1, 1, 0, 0, 2'b00, 0, 0);
        set_lane(1, 11, 1, 1, 0, 0, 2'b00, 0, 0);
        set_lane(2, 12, 1, 1, 0, 0, 2'b00, 0, 0);
        #1 check("R4 spill no stall", 64'(fin_stall), 64'h0);
        tick(); clear_lanes(); #0.1;
        check("R3 two valid", 64'(cmt_vld), 64'h3);
        check("R3 slot0 lane0", 64'(cmt_tag[0]), 64'd10);
        check("R3 slot1 lane1", 64'(cmt_tag[1]), 64'd11);
        tick();
        check("R4 spilled valid", 64'(cmt_vld), 64'h1);
        check("R4 spilled tag", 64'(cmt_tag[0]), 64'd12);
        tick();
        check("R6 empty after", 64'(cmt_vld), 64'h0);
    endtask

    task automatic t_midrow();
        set_lane(0, 20, 2, 1, 0, 0, 2'b00, 0, 0);
        tick(); clear_lanes();
        set_lane(0, 21, 1, 1, 0, 0, 2'b00, 0, 0);
        set_lane(1, 22, 1, 1, 0, 0, 2'b00, 0, 0);
        tick(); clear_lanes(); #0.1;
        check("R3 row order valid", 64'(cmt_vld), 64'h3);
        check("R3 earlier first", 64'(cmt_tag[0]), 64'd20);
        check("R3 first free slot", 64'(cmt_tag[1]), 64'd21);
        tick();
        check("R4 mid-row spill", 64'(cmt_vld), 64'h1);
        check("R4 mid-row tag", 64'(cmt_tag[0]), 64'd22);
        tick();
    endtask

    task automatic t_stall();
        set_lane(0, 30, 3, 1, 0, 0, 2'b00, 0, 0);
        set_lane(1, 31, 3, 1, 0, 0, 2'b00, 0, 0);
        set_lane(2, 32, 3, 1, 0, 0, 2'b00, 0, 0);
        #1 check("R5 stall lane2", 64'(fin_stall), 64'h4);
        tick(); clear_lanes(); #0.1;
        tick();
        tick();
        check("R5 kept lanes", 64'(cmt_vld), 64'h3);
        check("R5 kept tag0", 64'(cmt_tag[0]), 64'd30);
        check("R5 kept tag1", 64'(cmt_tag[1]), 64'd31);
        tick();
        check("R5 refused absent", 64'(cmt_vld), 64'h0);
    endtask

    task automatic t_zero_lat();
        set_lane(0, 40, 0, 1, 0, 0, 2'b00, 0, 0);
        tick(); clear_lanes(); #0.1;
        check("R10 zero as one", 64'(cmt_vld), 64'h1);
        check("R10 tag", 64'(cmt_tag[0]), 64'd40);
        tick();
    endtask

    task automatic t_flags();
        set_lane(0, 50, 1, 1, 0, 1, 2'b11, 1, 2);
        set_lane(1, 51, 1, 1, 1, 0, 2'b11, 4, 5);
        set_lane(2, 52, 1, 0, 0, 0, 2'b11, 6, 8);
        tick(); clear_lanes(); #0.1;
        check("R8 shown valid", 64'(cmt_vld), 64'h3);
        check("R8 ok low", 64'(cmt_ok), 64'h0);
        check("R8 no sb", 64'(sb_set), 64'h0);
        tick();
        check("R8 not-done valid", 64'(cmt_vld), 64'h1);
        check("R8 not-done ok", 64'(cmt_ok), 64'h0);
        check("R8 not-done sb", 64'(sb_set), 64'h0);
        tick();
    endtask

    task automatic t_multi_sb();
        set_lane(0, 60, 1, 1, 0, 0, 2'b11, 3, 7);
        set_lane(1, 61, 1, 1, 0, 0, 2'b01, 9, 12);
        tick(); clear_lanes(); #0.1;
        check("R7 ok both", 64'(cmt_ok), 64'h3);
        check("R7 sb union", 64'(sb_set), 64'h288);
        tick();
        check("R7 sb pulse", 64'(sb_set), 64'h0);
    endtask

    task automatic t_overlap();
        for (int i = 0; i < 10; i++) begin
            clear_lanes();
            set_lane(0, 2 * i, 1, 1, 0, 0, 2'b00, 0, 0);
            set_lane(1, 2 * i + 1, 1, 1, 0, 0, 2'b00, 0, 0);
            tick();
            check("R9 pair valid", 64'(cmt_vld), 64'h3);
            check("R9 tag0", 64'(cmt_tag[0]), 64'(2 * i));
            check("R6 tag1 after wrap", 64'(cmt_tag[1]), 64'(2 * i + 1));
        end
        clear_lanes();
        tick();
        check("R6 drained", 64'(cmt_vld), 64'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        clear_lanes();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        tick();
        t_latency();
        t_spill();
        t_midrow();
        t_stall();
        t_zero_lat();
        t_flags();
        t_multi_sb();
        t_overlap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule